// File: doc/BRIEF.md
# Lane-wise Carryless Multiply Unit

This block multiplies two operand vectors as polynomials over GF(2). Each vector is cut into 128-bit lanes, and every lane holds two 64-bit elements. Two bits of an 8-bit immediate choose, for every lane, which element of operand x and which element of operand y take part. The two chosen elements are multiplied with XOR in place of addition. The whole 128-bit product is written back into the matching result lane.

The unit has a single register stage. Operands and the immediate are captured on the clock edge at which `in_valid` is high, and the result and `out_valid` appear one cycle later. While `in_valid` is low the previous result stays on the output. A parameter sets the number of lanes, which fixes the vector width at 128, 256 or 512 bits. The typical uses are CRC folding, GHASH and other GF(2) polynomial arithmetic, where a wide datapath runs one independent multiply in each lane.

Top module: `lanewise_clmul`

## Requirements
- R1: Partial products are combined with bitwise XOR and never with carries. For example, 3 times 3 gives 5, so y multiplied by itself with the low/low selection, where y's low element is 3, gives 5.
- R2: Immediate bit 0 selects the x element in every lane. A value of 0 takes bits [63:0] of the lane and a value of 1 takes bits [127:64].
- R3: Immediate bit 4 selects the y element in every lane. A value of 0 takes bits [63:0] of the lane and a value of 1 takes bits [127:64].
- R4: A lane's 128-bit product is placed with its low 64 bits in lane bits [63:0] and its high 64 bits in lane bits [127:64]. With x = {high 5, low 1} and y = {high 9, low 3}, the immediates 0x00, 0x10, 0x01 and 0x11 give low words 3, 9, 15 and 45, each with a high word of 0.
- R5: Every lane is computed independently from its own operand bits, and the same immediate selection applies in every lane. Lane l occupies vector bits [128*l+127 : 128*l].
- R6: Immediate bits 1, 2, 3, 5, 6 and 7 have no effect on the result.
- R7: When `in_valid` is high at a rising edge, `result` shows the product and `out_valid` is 1 after that edge. When `in_valid` is low at a rising edge, `out_valid` is 0 after that edge.
- R8: Bit 127 of every lane's result is always 0.
- R9: While reset is asserted and after it is released, `out_valid` is 0 and `result` is all zeros until the first capture.
- R10: While `in_valid` is low, `result` holds its last value whatever the operands and the immediate do.
- R11: Swapping x and y gives the same result only if immediate bits 0 and 4 are also swapped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Capture strobe for the operands and the immediate |
| opx | input | 128*LANES | Operand vector x |
| opy | input | 128*LANES | Operand vector y |
| sel_imm | input | 8 | Element selection immediate (bit 0 for x, bit 4 for y) |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | 128*LANES | Registered per-lane 128-bit products |

## Verification
The bench uses a different lane value in every lane. A design that mixed up lane slices, or that applied the selection only in lane 0, would then return another lane's product. Each selection check uses operands whose high and low elements differ, so a swapped or ignored select bit returns a wrong value. The all-ones operands produce carries in every column of an ordinary multiplier, and an adder used by mistake would show up there as a wrong product or a set bit 127. Further tests set only the unused immediate bits, swap the operands with and without swapping the select bits, and change the inputs while `in_valid` is low. These catch decoding from the wrong bit position, a result that is not commutative-correct, and a register that loads without its strobe.

// File: rtl/clmul_pkg.sv
package clmul_pkg;
  localparam int ELEM_W    = 64;
  localparam int LANE_W    = 2 * ELEM_W;
  localparam int IMM_W     = 8;
  localparam int SEL_X_BIT = 0;
  localparam int SEL_Y_BIT = 4;

  typedef logic [ELEM_W-1:0] elem_t;
  typedef logic [LANE_W-1:0] lane_t;

  // GF(2) polynomial product: shifted copies of a, one per set bit of b, XOR-folded.
  function automatic lane_t clmul_poly(elem_t a, elem_t b);
    lane_t acc;
    acc = '0;
    for (int i = 0; i < ELEM_W; i++) begin
      if (b[i]) acc = acc ^ (lane_t'(a) << i);
    end
    return acc;
  endfunction
endpackage

// File: rtl/clmul_half_sel.sv
module clmul_half_sel
  import clmul_pkg::*;
(
  input  lane_t lane_in,
  input  logic  pick_hi,
  output elem_t elem_out
);
  assign elem_out = pick_hi ? lane_in[LANE_W-1:ELEM_W] : lane_in[ELEM_W-1:0];
endmodule

// File: rtl/clmul_core.sv
module clmul_core
  import clmul_pkg::*;
(
  input  elem_t a,
  input  elem_t b,
  output lane_t prod
);
  assign prod = clmul_poly(a, b);
endmodule

// File: rtl/clmul_lane.sv
module clmul_lane
  import clmul_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  lane_t x_lane,
  input  lane_t y_lane,
  input  logic  x_hi,
  input  logic  y_hi,
  output lane_t prod
);
  elem_t x_pick;
  elem_t y_pick;

  clmul_half_sel u_selx (.lane_in(x_lane), .pick_hi(x_hi), .elem_out(x_pick));
  clmul_half_sel u_sely (.lane_in(y_lane), .pick_hi(y_hi), .elem_out(y_pick));
  clmul_core     u_core (.a(x_pick), .b(y_pick), .prod(prod));

  // R1
  zero_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((x_pick == '0) || (y_pick == '0)) |-> (prod == '0));
  // R1
  unit_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (x_pick == elem_t'(1)) |-> (prod == {{ELEM_W{1'b0}}, y_pick}));
endmodule

// File: rtl/lanewise_clmul.sv
module lanewise_clmul
  import clmul_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [LANES*LANE_W-1:0]  opx,
  input  logic [LANES*LANE_W-1:0]  opy,
  input  logic [IMM_W-1:0]         sel_imm,
  output logic                     out_valid,
  output logic [LANES*LANE_W-1:0]  result
);
  localparam int VEC_W = LANES * LANE_W;

  logic       sel_x_hi;
  logic       sel_y_hi;
  logic [5:0] imm_spare;
  logic       valid_q;
  lane_t      lane_prod [LANES];
  lane_t      res_q     [LANES];

  assign sel_x_hi  = sel_imm[SEL_X_BIT];
  assign sel_y_hi  = sel_imm[SEL_Y_BIT];
  assign imm_spare = {sel_imm[7:5], sel_imm[3:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= in_valid;
  end
  assign out_valid = valid_q;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    clmul_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .x_lane (opx[l*LANE_W +: LANE_W]),
      .y_lane (opy[l*LANE_W +: LANE_W]),
      .x_hi   (sel_x_hi),
      .y_hi   (sel_y_hi),
      .prod   (lane_prod[l])
    );

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        res_q[l] <= '0;
      else if (in_valid) res_q[l] <= lane_prod[l];
    end
    assign result[l*LANE_W +: LANE_W] = res_q[l];

    // R8
    top_bit_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      result[l*LANE_W + LANE_W - 1] == 1'b0);
  end

  // R7
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  // R7
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R10
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result));
  // R6
  spare_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && $past(in_valid) && $stable(opx) && $stable(opy) &&
     $stable(sel_x_hi) && $stable(sel_y_hi) && !$stable(imm_spare)) |=> $stable(result));

  initial begin
    if (VEC_W != LANES * LANE_W || !(LANES == 1 || LANES == 2 || LANES == 4))
      $error("lanewise_clmul: LANES must be 1, 2 or 4");
  end
endmodule

// File: tb/lanewise_clmul_test.sv
`timescale 1ns/1ps
module lanewise_clmul_test;
  localparam int LANES = 4;
  localparam int W     = LANES * 128;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] opx = '0;
  logic [W-1:0] opy = '0;
  logic [7:0]   sel_imm = '0;
  logic         out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;

  lanewise_clmul #(.LANES(LANES)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opx(opx), .opy(opy),
    .sel_imm(sel_imm), .out_valid(out_valid), .result(result)
  );

  always #2.5 clk = ~clk;

  // Horner form over a's bits, MSB first: independent of the RTL's loop.
  function automatic logic [127:0] ref_mul(logic [63:0] a, logic [63:0] b);
    logic [127:0] acc = '0;
    for (int i = 63; i >= 0; i--) begin
      acc = acc << 1;
      if (a[i]) acc = acc ^ {64'b0, b};
    end
    return acc;
  endfunction

  function automatic logic [63:0] pick(logic [W-1:0] v, int lane, logic hi);
    return hi ? v[lane*128+64 +: 64] : v[lane*128 +: 64];
  endfunction

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic fire(logic [W-1:0] x, logic [W-1:0] y, logic [7:0] imm);
    @(negedge clk);
    opx = x; opy = y; sel_imm = imm; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  function automatic logic [W-1:0] expect_vec(logic [W-1:0] x, logic [W-1:0] y, logic [7:0] imm);
    logic [W-1:0] e;
    for (int l = 0; l < LANES; l++)
      e[l*128 +: 128] = ref_mul(pick(x, l, imm[0]), pick(y, l, imm[4]));
    return e;
  endfunction

  task automatic t_reset();
    check("R9 out_valid in reset", W'(out_valid), W'(0));
    check("R9 result in reset", result, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 out_valid after reset", W'(out_valid), W'(0));
    check("R9 result after reset", result, '0);
  endtask

  task automatic t_known_words();
    logic [W-1:0] x, y, e;
    logic [7:0] imms [4] = '{8'h00, 8'h10, 8'h01, 8'h11};
    logic [63:0] lows [4] = '{64'd3, 64'd9, 64'd15, 64'd45};
    for (int l = 0; l < LANES; l++) begin
      x[l*128 +: 128] = {64'd5, 64'd1};
      y[l*128 +: 128] = {64'd9, 64'd3};
    end
    for (int k = 0; k < 4; k++) begin
      fire(x, y, imms[k]);
      for (int l = 0; l < LANES; l++) e[l*128 +: 128] = {64'd0, lows[k]};
      check("R4 R2 R3 known selection words", result, e);
      check("R7 out_valid after capture", W'(out_valid), W'(1));
    end
  endtask

  task automatic t_square();
    logic [W-1:0] y, e;
    for (int l = 0; l < LANES; l++) begin
      y[l*128 +: 128] = {64'd9, 64'd3};
      e[l*128 +: 128] = 128'd5;
    end
    fire(y, y, 8'h00);
    check("R1 3 clmul 3 = 5", result, e);
  endtask

  task automatic t_random();
    logic [W-1:0] x, y;
    for (int r = 0; r < 6; r++) begin
      for (int w = 0; w < W / 32; w++) begin
        x[w*32 +: 32] = $urandom;
        y[w*32 +: 32] = $urandom;
      end
      for (int s = 0; s < 4; s++) begin
        logic [7:0] imm = {3'b000, s[1], 3'b000, s[0]};
        fire(x, y, imm);
        check("R5 R1 random per-lane product", result, expect_vec(x, y, imm));
      end
    end
  endtask

  task automatic t_spare_bits();
    logic [W-1:0] x, y;
    for (int l = 0; l < LANES; l++) begin
      x[l*128 +: 128] = {64'hA5A5_0000_1234_0001 + 64'(l), 64'h0F0F_0000_0000_0003 + 64'(l)};
      y[l*128 +: 128] = {64'h8000_0000_0000_0011 ^ 64'(l), 64'h0000_0000_00FF_0005 ^ 64'(l)};
    end
    fire(x, y, 8'hEE);
    check("R6 spare bits set, selection low/low", result, expect_vec(x, y, 8'h00));
    fire(x, y, 8'hFF);
    check("R6 spare bits set, selection high/high", result, expect_vec(x, y, 8'h11));
    fire(x, y, 8'h2F);
    check("R6 spare bits set, selection x high", result, expect_vec(x, y, 8'h01));
  endtask

  task automatic t_swap();
    logic [W-1:0] x, y, r1;
    for (int l = 0; l < LANES; l++) begin
      x[l*128 +: 128] = {64'h0000_0000_0000_0007, 64'h0000_0000_0000_0002};
      y[l*128 +: 128] = {64'h0000_0000_0000_000B, 64'h0000_0000_0000_0100};
    end
    fire(x, y, 8'h01);
    r1 = result;
    fire(y, x, 8'h10);
    check("R11 swap with swapped select bits", result, r1);
    fire(y, x, 8'h01);
    check("R11 swap without swapped bits", result, expect_vec(y, x, 8'h01));
    checks++;
    if (result === r1) begin
      errors++;
      $display("FAIL R11: actual %h expected a value other than %h", result, r1);
    end
  endtask

  task automatic t_hold();
    logic [W-1:0] keep;
    fire({W/8{8'h3C}}, {W/8{8'h5A}}, 8'h11);
    keep = result;
    @(negedge clk);
    opx = {W/8{8'hFF}}; opy = {W/8{8'h81}}; sel_imm = 8'h00;
    @(negedge clk);
    check("R10 result holds while idle", result, keep);
    check("R7 out_valid low after idle edge", W'(out_valid), W'(0));
  endtask

  task automatic t_all_ones();
    logic [W-1:0] x;
    logic [W-1:0] msb;
    x = '1;
    fire(x, x, 8'h11);
    check("R8 all-ones operands product", result, expect_vec(x, x, 8'h11));
    for (int l = 0; l < LANES; l++) msb[l*128 +: 128] = {1'b0, 127'd0} | (128'd1 << 127);
    check("R8 lane bit 127 clear", result & msb, '0);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    t_reset();
    t_known_words();
    t_square();
    t_random();
    t_spare_bits();
    t_swap();
    t_hold();
    t_all_ones();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule